// File: doc/BRIEF.md
# Parallel TSV Test Session Sequencer

This block runs pre-bond checks on a network of six through-silicon vias. It does not test each via on its own. It walks a fixed list of four overlapping groups, called sessions. For each session it asserts one enable bit per member via to the gated scan cells, waits for the probe capacitor to charge, and samples one pass/fail comparator. How long it waits depends on how many vias are enabled together.

A passing session clears every via in it. A failing session shows only that at least one member is bad. The session list places every via in two sessions, and any two sessions share at most one via. Because of this, one defective via can be located from the four session results. When the last session ends, the block builds a per-via fault map, drops busy and raises done.

The analog probe, the charge capacitor and the threshold detector lie outside the block. The block sees only their digital pass/fail result.

Top module: `tsv_session_seq`

## Requirements
- R1: After reset, tsv_en_o, busy_o, done_o and fault_map_o are all zero.
- R2: A start pulse while idle or done runs the sessions in this order. Bit k of tsv_en_o enables via k+1. The masks are 6'b000111, 6'b011001, 6'b101010 and 6'b110100.
- R3: tsv_en_o never has more than three bits set.
- R4: Each session holds its mask for 1 + W cycles. W is set by the popcount of the mask: 80 for one via, 53 for two, 42 for three and 38 for four or more.
- R5: pass_i (1 = capacitor charged, session passed) is sampled only on the last cycle in which the session's mask is driven.
- R6: A session's mask is constant while it is driven. tsv_en_o is zero for at least one cycle between consecutive sessions.
- R7: fault_map_o bit k is 1 exactly when every session containing via k+1 failed.
- R8: busy_o is 1 from the cycle after start until done_o rises. done_o and busy_o are never both 1. tsv_en_o is zero whenever busy_o is 0.
- R9: A start pulse received while busy_o is 1 has no effect. The run still performs exactly four sessions.
- R10: fault_map_o stays stable while the block is not busy, and changes only when a run completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a test run (ignored while busy) |
| pass_i | input | 1 | Comparator result, 1 = session passed |
| tsv_en_o | output | 6 | Per-via enable to the gated scan cells |
| busy_o | output | 1 | Run in progress |
| fault_map_o | output | 6 | Per-via fault flag, 1 = faulty |
| done_o | output | 1 | Run complete, map valid |

## Verification
Errors in the session index or the mask table show up as a wrong enable mask at the start of the next session burst. An off-by-one in the charge timer shows up as a burst one cycle too long or too short, so it is visible within the first session. The bench drives the correct comparator level only on the one cycle in which the design should sample it, and the opposite level on every other cycle. A sampling point that is early or late therefore flips a session result, and this corrupts the fault map that appears when done rises.

// File: rtl/tsv_seq_pkg.sv
package tsv_seq_pkg;
  localparam int N_TSV   = 6;
  localparam int N_SESS  = 4;
  localparam int MAX_ACT = 3;
  localparam int CNT_W   = 7;

  typedef enum logic [2:0] {
    S_IDLE, S_ENABLE, S_WAIT, S_SAMPLE, S_NEXT, S_DECODE, S_DONE
  } state_e;

  // bit k = via k+1
  function automatic logic [N_TSV-1:0] sess_mask(input int unsigned idx);
    case (idx)
      0:       return 6'b000111;
      1:       return 6'b011001;
      2:       return 6'b101010;
      default: return 6'b110100;
    endcase
  endfunction

  // charge wait at 100 MHz, by number of vias charging together
  function automatic int unsigned charge_cycles(input int unsigned n_act);
    case (n_act)
      1:       return 80;
      2:       return 53;
      3:       return 42;
      default: return 38;
    endcase
  endfunction
endpackage

// File: rtl/tsv_session_table.sv
module tsv_session_table #(
  parameter int N_TSV  = tsv_seq_pkg::N_TSV,
  parameter int N_SESS = tsv_seq_pkg::N_SESS,
  localparam int IDX_W  = $clog2(N_SESS),
  localparam int SIZE_W = $clog2(N_TSV + 1)
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [N_TSV-1:0]  mask_o,
  output logic [SIZE_W-1:0] size_o
);
  always_comb begin
    mask_o = tsv_seq_pkg::sess_mask(32'(idx_i));
    size_o = '0;
    for (int i = 0; i < N_TSV; i++) size_o = size_o + SIZE_W'(mask_o[i]);
  end
endmodule

// File: rtl/tsv_charge_timer.sv
module tsv_charge_timer #(
  parameter int CNT_W  = tsv_seq_pkg::CNT_W,
  parameter int SIZE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= CNT_W'(tsv_seq_pkg::charge_cycles(32'(size_i)) - 1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/tsv_fault_resolver.sv
module tsv_fault_resolver #(
  parameter int N_TSV = tsv_seq_pkg::N_TSV
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             commit_i,
  input  logic             pass_i,
  input  logic [N_TSV-1:0] mask_i,
  input  logic             decode_i,
  output logic [N_TSV-1:0] fault_o
);
  logic [N_TSV-1:0] good_q;
  logic [N_TSV-1:0] fault_q;

  for (genvar g = 0; g < N_TSV; g++) begin : g_tsv
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              good_q[g] <= 1'b0;
      else if (clear_i)                         good_q[g] <= 1'b0;
      else if (commit_i && pass_i && mask_i[g]) good_q[g] <= 1'b1;
    end

    // any passing session exonerates the via
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       fault_q[g] <= 1'b0;
      else if (decode_i) fault_q[g] <= ~good_q[g];
    end
  end

  assign fault_o = fault_q;
endmodule

// File: rtl/tsv_session_seq.sv
module tsv_session_seq #(
  parameter int N_TSV  = tsv_seq_pkg::N_TSV,
  parameter int N_SESS = tsv_seq_pkg::N_SESS,
  parameter int CNT_W  = tsv_seq_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             pass_i,
  output logic [N_TSV-1:0] tsv_en_o,
  output logic             busy_o,
  output logic [N_TSV-1:0] fault_map_o,
  output logic             done_o
);
  import tsv_seq_pkg::*;

  localparam int IDX_W  = $clog2(N_SESS);
  localparam int SIZE_W = $clog2(N_TSV + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SESS - 1);

  state_e            state_q, state_d;
  logic [IDX_W-1:0]  idx_q;
  logic [N_TSV-1:0]  mask;
  logic [SIZE_W-1:0] size;
  logic              pass_q;
  logic              timer_last;
  logic              launch;

  tsv_session_table #(.N_TSV(N_TSV), .N_SESS(N_SESS)) u_table (
    .idx_i  (idx_q),
    .mask_o (mask),
    .size_o (size)
  );

  tsv_charge_timer #(.CNT_W(CNT_W), .SIZE_W(SIZE_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (state_q == S_ENABLE),
    .size_i (size),
    .last_o (timer_last)
  );

  assign launch = start_i && (state_q == S_IDLE || state_q == S_DONE);

  tsv_fault_resolver #(.N_TSV(N_TSV)) u_resolver (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (launch),
    .commit_i (state_q == S_SAMPLE),
    .pass_i   (pass_q),
    .mask_i   (mask),
    .decode_i (state_q == S_DECODE),
    .fault_o  (fault_map_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE, S_DONE: if (launch) state_d = S_ENABLE;
      S_ENABLE:       state_d = S_WAIT;
      S_WAIT:         if (timer_last) state_d = S_SAMPLE;
      S_SAMPLE:       state_d = S_NEXT;
      S_NEXT:         state_d = (idx_q == LAST_IDX) ? S_DECODE : S_ENABLE;
      S_DECODE:       state_d = S_DONE;
      default:        state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      pass_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (launch)                                     idx_q <= '0;
      else if (state_q == S_NEXT && idx_q != LAST_IDX) idx_q <= idx_q + 1'b1;
      if (state_q == S_WAIT && timer_last)            pass_q <= pass_i;
    end
  end

  // SAMPLE and NEXT drop enables: discharge gap
  assign tsv_en_o = (state_q == S_ENABLE || state_q == S_WAIT) ? mask : '0;
  assign busy_o   = !(state_q == S_IDLE || state_q == S_DONE);
  assign done_o   = (state_q == S_DONE);
endmodule

// File: rtl/tsv_session_seq_chk.sv
module tsv_session_seq_chk #(
  parameter int N_TSV   = tsv_seq_pkg::N_TSV,
  parameter int MAX_ACT = tsv_seq_pkg::MAX_ACT
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_TSV-1:0] tsv_en_i,
  input logic             busy_i,
  input logic             done_i,
  input logic [N_TSV-1:0] fault_map_i
);
  p_max_active_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(tsv_en_i) <= MAX_ACT);

  p_mask_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tsv_en_i != '0 && $past(tsv_en_i) != '0) |-> tsv_en_i == $past(tsv_en_i));

  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> tsv_en_i == '0);

  p_busy_done_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_i && done_i));

  p_done_after_run_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> $past(busy_i));

  p_map_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !$past(busy_i)) |-> $stable(fault_map_i));
endmodule

bind tsv_session_seq tsv_session_seq_chk #(.N_TSV(N_TSV)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tsv_en_i    (tsv_en_o),
  .busy_i      (busy_o),
  .done_i      (done_o),
  .fault_map_i (fault_map_o)
);

// File: tb/tsv_session_seq_bench.sv
module tsv_session_seq_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       pass = 1'b0;
  logic [5:0] tsv_en;
  logic       busy;
  logic [5:0] fault_map;
  logic       done;

  tsv_session_seq u_tsv_session_seq (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .pass_i      (pass),
    .tsv_en_o    (tsv_en),
    .busy_o      (busy),
    .fault_map_o (fault_map),
    .done_o      (done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  logic [5:0] fault_inj = '0;

  logic [5:0] exp_mask_q[$];
  int         exp_len_q[$];
  logic [5:0] exp_map_q[$];

  function automatic logic [5:0] spec_mask(input int s);
    case (s)
      0: return 6'b000111;
      1: return 6'b011001;
      2: return 6'b101010;
      default: return 6'b110100;
    endcase
  endfunction

  function automatic int ones(input logic [5:0] v);
    int n = 0;
    for (int i = 0; i < 6; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic int spec_len(input logic [5:0] m);
    case (ones(m))
      1: return 81;
      2: return 54;
      3: return 43;
      default: return 39;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary_and_end();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // monitor: models the comparator and scores each session burst
  int         k = 0;
  logic [5:0] cur_mask = '0;
  logic       done_d = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (tsv_en != '0) begin
        if (k == 0) begin
          cur_mask = tsv_en;
          check(ones(tsv_en) <= 3, "R3 active count", ones(tsv_en), 3);
          check(busy == 1'b1, "R8 busy during session", int'(busy), 1);
        end else if (tsv_en != cur_mask) begin
          check(1'b0, "R6 mask changed mid-session", int'(tsv_en), int'(cur_mask));
        end
        k++;
        // correct level only on the cycle the design must sample (R5)
        pass = (k == spec_len(tsv_en)) ? ((tsv_en & fault_inj) == '0)
                                       : ((tsv_en & fault_inj) != '0);
      end else begin
        pass = 1'b0;
        if (k > 0) begin
          if (exp_mask_q.size() == 0) begin
            check(1'b0, "R9 unexpected session", int'(cur_mask), 0);
          end else begin
            logic [5:0] em;
            int el;
            em = exp_mask_q.pop_front();
            el = exp_len_q.pop_front();
            check(cur_mask == em, "R2 session mask", int'(cur_mask), int'(em));
            check(k == el, "R4 session length", k, el);
          end
          k = 0;
        end
      end
      if (done && !done_d) begin
        if (exp_map_q.size() == 0) begin
          check(1'b0, "R7 unexpected done", int'(fault_map), 0);
        end else begin
          logic [5:0] ex;
          ex = exp_map_q.pop_front();
          check(fault_map == ex, "R7/R5 fault map", int'(fault_map), int'(ex));
        end
      end
      done_d = done;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      summary_and_end();
    end
  end

  // driver: pushes expectations, then runs one test
  task automatic run_case(input logic [5:0] f, input bit poke);
    logic [5:0] good = '0;
    logic [5:0] held;
    fault_inj = f;
    for (int s = 0; s < 4; s++) begin
      exp_mask_q.push_back(spec_mask(s));
      exp_len_q.push_back(spec_len(spec_mask(s)));
      if ((spec_mask(s) & f) == '0) good |= spec_mask(s);
    end
    exp_map_q.push_back(~good);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy == 1'b1, "R8 busy after start", int'(busy), 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      repeat (60) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    check(exp_mask_q.size() == 0, "R9 session count", exp_mask_q.size(), 0);
    check(busy == 1'b0 && done == 1'b1, "R8 done state", int'({busy, done}), 1);
    check(tsv_en == '0, "R8 enables off when done", int'(tsv_en), 0);
    held = fault_map;
    repeat (12) @(negedge clk);
    check(fault_map == held, "R10 map held", int'(fault_map), int'(held));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(tsv_en == '0 && busy == 1'b0 && done == 1'b0 && fault_map == '0,
          "R1 reset state", int'({tsv_en, busy, done, fault_map}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(tsv_en == '0 && busy == 1'b0, "R1 idle after reset", int'({tsv_en, busy}), 0);

    run_case(6'b000000, 1'b0);
    for (int t = 0; t < 6; t++) run_case(6'b000001 << t, t == 2);
    run_case(6'b000011, 1'b1);   // R7 double fault: only all-failed vias flagged
    run_case(6'b000000, 1'b0);
    summary_and_end();
  end
endmodule